// File: doc/BRIEF.md
# Boot ROM Window with One-Way Lockout

This block sits on a processor's 32-bit memory bus and answers reads in a 2 KB window placed at the processor's reset vector, 32'hBFC0_0000. The lower 1984 bytes of the window hold a boot ROM whose contents come from a parameter image. The upper 64 bytes hold a small scratch RAM that the processor may read and write. A read strobe is answered one clock later with data and a one-cycle valid pulse. Addresses outside the window get no answer.

A gating controller holds the processor's non-maskable interrupt line asserted after reset. It releases the line only when an external security handshake reports success, so the processor starts fetching from the window. Once released, the line stays released until the next reset.

When boot code has finished, it writes a word with the lock bit set to the last RAM word. From then until the next reset, every ROM read returns zero. The scratch RAM keeps working normally.

Top module: `boot_win`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `nmi_hold` is 1 and `bus_rvalid` and `bus_rdata` are 0. A reset also clears the lockout, so ROM reads return image data again.
- R2: `nmi_hold` falls at the clock edge that samples `sec_ok` high for the HS_CYCLES-th (default 4) consecutive time.
- R3: A low sample of `sec_ok` before release restarts the consecutive count, and `nmi_hold` stays 1.
- R4: Once `nmi_hold` is 0 it stays 0 whatever `sec_ok` does, until `rst`.
- R5: Before lockout, a read of address 32'hBFC0_0000 + 4*i (i from 0 to 495) returns image word i one cycle after `bus_rd`, with `bus_rvalid` = 1. The default image word i is (i * 32'h0101_0101) XOR 32'hB007_0000.
- R6: The 16 RAM words at window offsets 0x7C0 to 0x7FC return the last full word written to them.
- R7: Writes to ROM offsets (0x000 to 0x7BF) never change what ROM reads return.
- R8: A write to offset 0x7FC with data bit 4 set turns on the lockout. From the next cycle on, ROM reads return 32'h0 with `bus_rvalid` = 1. A write to 0x7FC with bit 4 clear does not lock.
- R9: The lockout stays on until `rst`, including through later writes with bit 4 clear. The RAM stays readable and writable while locked.
- R10: A read outside the window leaves `bus_rvalid` and `bus_rdata` at 0. A write outside the window changes no RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 32 | Byte address; bits 1:0 ignored |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not valid |
| bus_rvalid | output | 1 | One-cycle pulse marking read data |
| sec_ok | input | 1 | Security handshake success level |
| nmi_hold | output | 1 | 1 while the processor's NMI is held |

## Verification
The assertions assume that a read strobe and a write strobe never share a cycle. They also assume that `sec_ok` is a synchronous level, so each clock edge samples it once. The bench drives every strobe alone on the falling edge and keeps `sec_ok` steady between falling edges. It never issues a read in the same cycle as the locking write, so lock timing is observed only on reads that follow the lock.

// File: rtl/boot_win_pkg.sv
package boot_win_pkg;

  localparam int DEF_ROM_BYTES = 1984;
  localparam int DEF_ROM_WORDS = DEF_ROM_BYTES / 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_ZERO = 2'd3
  } rsrc_e;

  // Default image: word i = (i * 0x01010101) ^ 0xB0070000
  function automatic logic [DEF_ROM_BYTES*8-1:0] default_image();
    logic [DEF_ROM_BYTES*8-1:0] img;
    img = '0;
    for (int i = 0; i < DEF_ROM_WORDS; i++) begin
      img[i*32 +: 32] = (32'(i) * 32'h0101_0101) ^ 32'hB007_0000;
    end
    return img;
  endfunction

endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
  parameter logic [31:0] BASE_ADDR = 32'hBFC0_0000,
  parameter int ROM_WORDS = 496,
  parameter int RAM_WORDS = 16,
  localparam int WIN_AW  = $clog2((ROM_WORDS + RAM_WORDS) * 4),
  localparam int WORD_W  = WIN_AW - 2,
  localparam int ROM_IW  = $clog2(ROM_WORDS),
  localparam int RAM_AW  = $clog2(RAM_WORDS)
) (
  input  logic [31:0]       addr,
  output logic              in_rom,
  output logic              in_ram,
  output logic [ROM_IW-1:0] rom_idx,
  output logic [RAM_AW-1:0] ram_idx
);

  logic              in_win;
  logic [WORD_W-1:0] word_idx;
  logic [WORD_W-1:0] ram_off;
  logic              unused_bits;

  always_comb begin
    in_win   = (addr[31:WIN_AW] == BASE_ADDR[31:WIN_AW]);
    word_idx = addr[WIN_AW-1:2];
    in_rom   = in_win && (word_idx < WORD_W'(ROM_WORDS));
    in_ram   = in_win && !(word_idx < WORD_W'(ROM_WORDS));
    rom_idx  = word_idx[ROM_IW-1:0];
    ram_off  = word_idx - WORD_W'(ROM_WORDS);
    ram_idx  = ram_off[RAM_AW-1:0];
  end

  assign unused_bits = ^{addr[1:0], ram_off, word_idx};

endmodule

// File: rtl/boot_win_rom.sv
module boot_win_rom #(
  parameter int ROM_WORDS = 496,
  parameter logic [ROM_WORDS*32-1:0] IMAGE = '0,
  localparam int IW = $clog2(ROM_WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [31:0]   q
);

  logic [31:0] words [ROM_WORDS];

  for (genvar g = 0; g < ROM_WORDS; g++) begin : g_word
    assign words[g] = IMAGE[g*32 +: 32];
  end

  // Registered read, no reset: maps onto a block RAM output register.
  always_ff @(posedge clk) begin
    if (en) q <= words[idx];
  end

endmodule

// File: rtl/boot_win_scratch.sv
module boot_win_scratch #(
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [31:0]   wdata,
  input  logic          re,
  output logic [31:0]   q
);

  logic [31:0] mem [WORDS];

  // Single port, read-first.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end

endmodule

// File: rtl/boot_win_nmi_gate.sv
module boot_win_nmi_gate #(
  parameter int HS_CYCLES = 4,
  localparam int CW = $clog2(HS_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_ok,
  output logic nmi_hold
);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_hold <= 1'b1;
      run_q    <= '0;
    end else if (nmi_hold) begin
      if (!sec_ok) begin
        run_q <= '0;
      end else if (run_q == CW'(HS_CYCLES - 1)) begin
        nmi_hold <= 1'b0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/boot_win_lock.sv
module boot_win_lock (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic locked
);

  always_ff @(posedge clk) begin
    if (rst)      locked <= 1'b0;
    else if (set) locked <= 1'b1;
  end

endmodule

// File: rtl/boot_win.sv
module boot_win #(
  parameter logic [31:0] BASE_ADDR = 32'hBFC0_0000,
  parameter int ROM_BYTES = boot_win_pkg::DEF_ROM_BYTES,
  parameter int RAM_BYTES = 64,
  parameter int HS_CYCLES = 4,
  parameter int LOCK_BIT  = 4,
  parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE = boot_win_pkg::default_image()
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        sec_ok,
  output logic        nmi_hold
);
  import boot_win_pkg::*;

  localparam int ROM_WORDS = ROM_BYTES / 4;
  localparam int RAM_WORDS = RAM_BYTES / 4;
  localparam int ROM_IW    = $clog2(ROM_WORDS);
  localparam int RAM_AW    = $clog2(RAM_WORDS);

  logic              in_rom, in_ram;
  logic [ROM_IW-1:0] rom_idx;
  logic [RAM_AW-1:0] ram_idx;
  logic              lock_q, lock_set;
  logic              rom_en, ram_we, ram_re;
  logic [31:0]       rom_q, ram_q;
  rsrc_e             src_q;

  boot_win_decode #(
    .BASE_ADDR(BASE_ADDR), .ROM_WORDS(ROM_WORDS), .RAM_WORDS(RAM_WORDS)
  ) u_dec (
    .addr(bus_addr), .in_rom(in_rom), .in_ram(in_ram),
    .rom_idx(rom_idx), .ram_idx(ram_idx)
  );

  assign rom_en   = bus_rd && in_rom && !lock_q;
  assign ram_re   = bus_rd && in_ram;
  assign ram_we   = bus_wr && in_ram;
  assign lock_set = ram_we && (ram_idx == RAM_AW'(RAM_WORDS - 1)) && bus_wdata[LOCK_BIT];

  boot_win_rom #(.ROM_WORDS(ROM_WORDS), .IMAGE(ROM_IMAGE)) u_rom (
    .clk(clk), .en(rom_en), .idx(rom_idx), .q(rom_q)
  );

  boot_win_scratch #(.WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .idx(ram_idx), .we(ram_we), .wdata(bus_wdata),
    .re(ram_re), .q(ram_q)
  );

  boot_win_lock u_lock (.clk(clk), .rst(rst), .set(lock_set), .locked(lock_q));

  boot_win_nmi_gate #(.HS_CYCLES(HS_CYCLES)) u_nmi (
    .clk(clk), .rst(rst), .sec_ok(sec_ok), .nmi_hold(nmi_hold)
  );

  always_ff @(posedge clk) begin
    if (rst)                   src_q <= SRC_NONE;
    else if (bus_rd && in_rom) src_q <= lock_q ? SRC_ZERO : SRC_ROM;
    else if (bus_rd && in_ram) src_q <= SRC_RAM;
    else                       src_q <= SRC_NONE;
  end

  always_comb begin
    bus_rvalid = (src_q != SRC_NONE);
    unique case (src_q)
      SRC_ROM: bus_rdata = rom_q;
      SRC_RAM: bus_rdata = ram_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/boot_win_checks.sv
module boot_win_checks #(
  parameter logic [31:0] BASE_ADDR = 32'hBFC0_0000,
  parameter int ROM_BYTES = 1984,
  parameter int RAM_BYTES = 64
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] bus_addr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        sec_ok,
  input logic        nmi_hold,
  input logic        locked
);
  localparam int WIN_AW = $clog2(ROM_BYTES + RAM_BYTES);

  logic c_in_win, c_in_rom;
  logic unused_lo;
  assign c_in_win  = (bus_addr[31:WIN_AW] == BASE_ADDR[31:WIN_AW]);
  assign c_in_rom  = c_in_win && ({bus_addr[WIN_AW-1:2], 2'b00} < WIN_AW'(ROM_BYTES));
  assign unused_lo = ^bus_addr[1:0];

  assert_release_needs_ok_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_hold) |-> $past(sec_ok));

  assert_nmi_no_reassert_R4: assert property (@(posedge clk) disable iff (rst)
    !nmi_hold |=> !nmi_hold);

  assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));

  assert_locked_rom_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_in_rom && locked) |=> (bus_rvalid && bus_rdata == 32'h0));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_outside_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !c_in_win) |=> (!bus_rvalid && bus_rdata == 32'h0));

endmodule

bind boot_win boot_win_checks #(
  .BASE_ADDR(BASE_ADDR), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)
) u_checks (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .sec_ok(sec_ok),
  .nmi_hold(nmi_hold), .locked(lock_q)
);

// File: tb/test_boot_win.sv
`timescale 1ns/1ps
module test_boot_win;
  localparam logic [31:0] BASE = 32'hBFC0_0000;
  localparam int ROMW = 496;
  localparam int RAMW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sec_ok = 1'b0;
  logic        nmi_hold;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  boot_win i_boot_win (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sec_ok(sec_ok), .nmi_hold(nmi_hold)
  );

  function automatic logic [31:0] img(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hB007_0000;
  endfunction

  function automatic logic [31:0] pat(input int j, input logic [31:0] salt);
    return ((32'(j) * 32'h0001_0011) ^ salt) & ~32'h10;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1; d = bus_rdata; v = bus_rvalid;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rom_sweep(input bool_zero, input string req);
    logic [31:0] d; logic v; logic [31:0] e;
    for (int i = 0; i < ROMW; i++) begin
      rd(BASE + 32'(4*i), d, v);
      e = bool_zero ? 32'h0 : img(i);
      chk(v && d == e, req, d, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v;
    repeat (3) @(posedge clk); #1;
    chk(nmi_hold == 1'b1, "R1 nmi in reset", 32'(nmi_hold), 1);
    chk(!bus_rvalid && bus_rdata == 0, "R1 bus idle in reset", bus_rdata, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(nmi_hold == 1'b1 && !bus_rvalid, "R1 after reset", 32'(nmi_hold), 1);

    // R2/R3: three highs, a low, then four highs
    @(negedge clk); sec_ok = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(nmi_hold == 1'b1, "R2 held after 3 highs", 32'(nmi_hold), 1);
    @(negedge clk); sec_ok = 1'b0;
    @(posedge clk); #1;
    chk(nmi_hold == 1'b1, "R3 held on low sample", 32'(nmi_hold), 1);
    @(negedge clk); sec_ok = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(nmi_hold == 1'b1, "R3 count restarted", 32'(nmi_hold), 1);
    @(posedge clk); #1;
    chk(nmi_hold == 1'b0, "R2 released on 4th high", 32'(nmi_hold), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); sec_ok = k[0];
      @(posedge clk); #1;
      chk(nmi_hold == 1'b0, "R4 no reassert", 32'(nmi_hold), 0);
    end

    rom_sweep(1'b0, "R5 rom read");

    // R7: writes into the ROM region
    for (int i = 0; i < ROMW; i += 7) wr(BASE + 32'(4*i), 32'hDEAD_0000 ^ 32'(i));
    rom_sweep(1'b0, "R7 rom unchanged");

    // R6: scratch RAM fill and readback
    for (int j = 0; j < RAMW; j++) wr(BASE + 32'h7C0 + 32'(4*j), pat(j, 32'h5A5A_A5A5));
    for (int j = 0; j < RAMW; j++) begin
      rd(BASE + 32'h7C0 + 32'(4*j), d, v);
      chk(v && d == pat(j, 32'h5A5A_A5A5), "R6 ram readback", d, pat(j, 32'h5A5A_A5A5));
    end
    rd(BASE + 32'h10, d, v);
    chk(v && d == img(4), "R8 bit4 clear does not lock", d, img(4));

    // R10: outside the window
    rd(BASE - 32'h4, d, v);
    chk(!v && d == 0, "R10 below window", d, 0);
    rd(BASE + 32'h800, d, v);
    chk(!v && d == 0, "R10 above window", d, 0);
    rd(32'h0000_07C0, d, v);
    chk(!v && d == 0, "R10 alias low", d, 0);
    wr(BASE + 32'h800 + 32'h7C0, 32'hFFFF_FFFF);
    wr(32'h0000_07FC, 32'hFFFF_FFFF);
    rd(BASE + 32'h7C0, d, v);
    chk(v && d == pat(0, 32'h5A5A_A5A5), "R10 outside write ignored", d, pat(0, 32'h5A5A_A5A5));
    rd(BASE + 32'h7FC, d, v);
    chk(v && d == pat(15, 32'h5A5A_A5A5), "R10 outside write no lock", d, pat(15, 32'h5A5A_A5A5));
    rd(BASE, d, v);
    chk(v && d == img(0), "R10 rom still open", d, img(0));

    // R8: lock
    wr(BASE + 32'h7FC, 32'h1234_0010);
    rom_sweep(1'b1, "R8 rom zero after lock");
    rd(BASE + 32'h7FC, d, v);
    chk(v && d == 32'h1234_0010, "R9 lock word readable", d, 32'h1234_0010);
    for (int j = 0; j < RAMW - 1; j++) wr(BASE + 32'h7C0 + 32'(4*j), pat(j, 32'h0F0F_3C3C));
    wr(BASE + 32'h7FC, 32'h0000_0000);
    for (int j = 0; j < RAMW - 1; j++) begin
      rd(BASE + 32'h7C0 + 32'(4*j), d, v);
      chk(v && d == pat(j, 32'h0F0F_3C3C), "R9 ram works locked", d, pat(j, 32'h0F0F_3C3C));
    end
    for (int i = 0; i < ROMW; i += 31) begin
      rd(BASE + 32'(4*i), d, v);
      chk(v && d == 0, "R9 lock sticky", d, 0);
    end
    chk(nmi_hold == 1'b0, "R4 still released", 32'(nmi_hold), 0);

    // R1: reset clears lock and re-holds NMI
    @(negedge clk); rst = 1'b1; sec_ok = 1'b0;
    @(posedge clk); #1;
    chk(nmi_hold == 1'b1, "R1 nmi held after reset", 32'(nmi_hold), 1);
    @(negedge clk); rst = 1'b0;
    rd(BASE + 32'h14, d, v);
    chk(v && d == img(5), "R1 lock cleared by reset", d, img(5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule